// File: doc/BRIEF.md
# Shared Memory Map and Display Clear Engine

This block sits between a microcontroller's external-data bus and one embedded byte-wide RAM. The RAM holds two regions: a 0.75 KB general-purpose auxiliary region and a 1.25 KB display region. The decoder turns each CPU address into a physical RAM address. The display region appears in one of two logical windows, chosen by a mode input: a text window at 2000H or a caption window at 8000H. Both windows lead to the same physical bytes. An address outside the active windows is a miss. A read that misses returns FFH, and a write that misses is dropped.

A built-in sequencer fills the first 1 KB of the display region with the space code 20H. It runs after power-on reset, on a reset request, and when idle mode ends because of a reset. It does not run when idle ends through an interrupt. It writes one byte per clock in ascending order and holds `busy` high while it runs. CPU accesses made during that time get a stall and do not reach the RAM. A new reset during a fill starts the fill again from its first byte. The auxiliary region and the last 256 display bytes are never written by the hardware.

The RAM is expected to return read data one clock after the read strobe.

Top module: `shmem_map`

## Requirements
- R1: CPU addresses 0000H..02FFH hit and map to physical addresses 000H..2FFH, whatever the mode.
- R2: With `mode_cc`=0, CPU addresses 2000H..24FFH hit and map to physical 300H + (addr - 2000H).
- R3: With `mode_cc`=1, CPU addresses 8000H..84FFH hit and map to the same physical bytes 300H + (addr - 8000H). The window of the inactive mode misses.
- R4: A miss drives `hit`=0. A read that misses returns FFH, and a write that misses raises no `ram_we` and changes no RAM byte.
- R5: After `rst_n` is released, `busy` is high for exactly 1024 cycles. During that time the RAM receives 20H at physical 300H..6FFH, one address per cycle, in ascending order.
- R6: A fill never writes physical 000H..2FFH or 700H..7FFH.
- R7: While `busy` is high, a CPU read or write raises `cpu_stall`, produces no `ram_re`, and does not reach the RAM.
- R8: A pulse on `wake_vld` with `wake_by_int`=1 starts no fill. Display contents are kept.
- R9: A pulse on `reset_req`, or on `wake_vld` with `wake_by_int`=0, starts a fill that keeps `busy` high for the 1024 cycles that follow. This also applies during a fill already in progress, which restarts from 300H.
- R10: Read data for a CPU read appears on `cpu_rdata` in the clock cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; starts a fill on release |
| reset_req | input | 1 | One-cycle reset request; starts or restarts a fill |
| wake_vld | input | 1 | One-cycle pulse marking the end of idle mode |
| wake_by_int | input | 1 | Cause of the idle exit: 1 means interrupt, 0 means reset |
| mode_cc | input | 1 | Display window select: 0 selects text, 1 selects caption |
| cpu_addr | input | 16 | CPU external-data address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the read |
| cpu_stall | output | 1 | CPU access held off because a fill is running |
| hit | output | 1 | The current CPU address lies in an active window |
| busy | output | 1 | A fill is in progress |
| ram_addr | output | 11 | Physical RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |

## Verification
The bench uses boundary addresses: the last auxiliary byte, the first and last byte of each window, the byte just past each window, and the window of the mode that is not selected. A decoder with an off-by-one or a stale window would alias the wrong bytes or accept writes that should miss.

It counts the busy cycles after power-on, after a reset request, after a reset-caused wake, and after a restart in the middle of a fill. A wrong fill length would show up, and so would a restart that continues from the old position instead of starting over. After each fill it reads back all 2 KB through the windows. A fill that runs into the last 256 display bytes or the auxiliary region would show up there. So would an interrupt wake that wipes the display.

// File: rtl/shmem_map.sv
module shmem_map #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PW         = 11,
  parameter int AUX_BYTES  = 768,
  parameter int DISP_BYTES = 1280,
  parameter int CLR_BYTES  = 1024,
  parameter logic [AW-1:0] TXT_BASE = 16'h2000,
  parameter logic [AW-1:0] CC_BASE  = 16'h8000,
  parameter logic [DW-1:0] FILL     = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_req,
  input  logic          wake_vld,
  input  logic          wake_by_int,
  input  logic          mode_cc,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          hit,
  output logic          busy,
  output logic [PW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);

  localparam int CW = $clog2(CLR_BYTES);
  localparam logic [PW-1:0] DISP_PHYS = PW'(AUX_BYTES);
  localparam logic [CW-1:0] CNT_LAST  = CW'(CLR_BYTES - 1);

  logic [AW-1:0] win_base, win_off;
  logic          aux_hit, disp_hit, restart, miss_q;
  logic [PW-1:0] cpu_phys;
  logic [CW-1:0] cnt;

  assign win_base = mode_cc ? CC_BASE : TXT_BASE;
  assign win_off  = cpu_addr - win_base;
  assign aux_hit  = cpu_addr < AW'(AUX_BYTES);
  assign disp_hit = (cpu_addr >= win_base) && (win_off < AW'(DISP_BYTES));
  assign hit      = aux_hit | disp_hit;
  assign cpu_phys = aux_hit ? PW'(cpu_addr) : DISP_PHYS + PW'(win_off);

  assign restart  = reset_req | (wake_vld & ~wake_by_int);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (restart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_LAST) busy <= 1'b0;
    end
  end

  assign ram_addr  = busy ? DISP_PHYS + PW'(cnt) : cpu_phys;
  assign ram_we    = busy | (cpu_wr & hit);
  assign ram_re    = ~busy & cpu_rd & hit;
  assign ram_wdata = busy ? FILL : cpu_wdata;
  assign cpu_stall = busy & (cpu_rd | cpu_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              miss_q <= 1'b0;
    else if (cpu_rd & ~busy) miss_q <= ~hit;
  end

  assign cpu_rdata = miss_q ? '1 : ram_rdata;

  a_r5_fill_in_block0: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ram_we && ram_wdata == FILL && ram_addr >= DISP_PHYS &&
              ram_addr < DISP_PHYS + PW'(CLR_BYTES)));

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n) && !$past(restart)) |->
      ram_addr == $past(ram_addr) + PW'(1));

  a_r9_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (busy && ram_addr == DISP_PHYS));

  a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ram_re);

  a_r4_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cpu_wr && !hit) |-> !ram_we);

  a_r8_int_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wake_vld && wake_by_int && !reset_req) |=> !busy);

endmodule

// File: tb/shmem_map_bench.sv
module shmem_map_bench;
  logic clk = 0, rst_n = 0, reset_req = 0, wake_vld = 0, wake_by_int = 0, mode_cc = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0, ram_rdata = 0;
  logic [7:0] cpu_rdata, ram_wdata;
  logic cpu_stall, hit, busy, ram_we, ram_re;
  logic [10:0] ram_addr;
  logic [7:0] mem [2048];
  logic [7:0] exp_m [2048];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  shmem_map u_shmem_map (.clk, .rst_n, .reset_req, .wake_vld, .wake_by_int, .mode_cc,
    .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .cpu_rdata, .cpu_stall, .hit, .busy,
    .ram_addr, .ram_we, .ram_re, .ram_wdata, .ram_rdata);

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit map_of(input logic [15:0] a, input bit cc, output int ph);
    int base = cc ? 'h8000 : 'h2000;
    ph = 0;
    if (a < 16'h0300) begin ph = int'(a); return 1; end
    if (int'(a) >= base && int'(a) < base + 1280) begin ph = 'h300 + int'(a) - base; return 1; end
    return 0;
  endfunction

  task automatic model_fill();
    for (int i = 'h300; i < 'h700; i++) exp_m[i] = 8'h20;
  endtask

  task automatic do_read(input logic [15:0] a, input bit cc, input string req);
    int ph; bit h; logic [7:0] e;
    h = map_of(a, cc, ph);
    e = h ? exp_m[ph] : 8'hFF;
    cpu_addr = a; mode_cc = cc; cpu_rd = 1;
    #1 chk(hit == h, req, hit, h);
    @(negedge clk);
    cpu_rd = 0;
    chk(cpu_rdata == e, req, cpu_rdata, e);
  endtask

  task automatic do_write(input logic [15:0] a, input bit cc, input logic [7:0] d, input string req);
    int ph; bit h;
    h = map_of(a, cc, ph);
    cpu_addr = a; mode_cc = cc; cpu_wdata = d; cpu_wr = 1;
    #1 chk(hit == h && ram_we == h, req, {hit, ram_we}, {h, h});
    if (h) exp_m[ph] = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic count_busy(input int expv, input int stall_at, input string req);
    int n = 0;
    while (busy && n < 5000) begin
      if (n == stall_at) begin
        cpu_addr = 16'h0010; cpu_rd = 1;
        #1 chk(cpu_stall && !ram_re, "R7 stall", {cpu_stall, ram_re}, 2);
      end
      n++;
      @(negedge clk);
      cpu_rd = 0;
    end
    chk(n == expv, req, n, expv);
  endtask

  task automatic sweep(input bit cc, input string req);
    for (int i = 0; i < 768; i++) do_read(16'(i), cc, req);
    for (int i = 0; i < 1280; i++) do_read(16'((cc ? 'h8000 : 'h2000) + i), cc, req);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_m[i] = mem[i];
    end
    model_fill();
    repeat (3) @(negedge clk);
    chk(busy == 1, "R5 reset busy", busy, 1);
    rst_n = 1;
    count_busy(1024, 300, "R5 power-on fill length");
    sweep(0, "R5/R6 after power-on R2");
    sweep(1, "R3 caption alias");

    do_read(16'h02FF, 0, "R1 last aux");
    do_read(16'h0300, 1, "R4 past aux");
    do_read(16'h24FF, 0, "R2 last text");
    do_read(16'h2500, 0, "R4 past text");
    do_read(16'h84FF, 1, "R3 last caption");
    do_read(16'h8500, 1, "R4 past caption");
    do_read(16'h2000, 1, "R3 text window inactive");
    do_read(16'h8000, 0, "R3 caption window inactive");
    do_write(16'h2500, 0, 8'h11, "R4 miss write");
    do_write(16'h8000, 0, 8'h12, "R4 inactive write");
    do_write(16'h24FF, 0, 8'hC3, "R2 write last");
    do_read(16'h84FF, 1, "R3 alias of write");

    for (int k = 0; k < 600; k++) begin
      logic [15:0] a; bit cc; int s;
      cc = 1'($urandom);
      s = $urandom % 4;
      case (s)
        0: a = 16'($urandom % 768);
        1: a = 16'('h2000 + $urandom % 1300);
        2: a = 16'('h8000 + $urandom % 1300);
        default: a = 16'($urandom);
      endcase
      if ($urandom % 2) do_write(a, cc, 8'($urandom), "R1-4 random write");
      else do_read(a, cc, "R10 random read");
    end

    wake_by_int = 1; wake_vld = 1;
    @(negedge clk); wake_vld = 0;
    chk(busy == 0, "R8 interrupt wake", busy, 0);
    sweep(0, "R8 contents kept");

    wake_by_int = 0; wake_vld = 1;
    @(negedge clk); wake_vld = 0;
    model_fill();
    count_busy(1024, 50, "R9 reset wake fill length");
    sweep(1, "R9/R6 after reset wake");

    for (int i = 0; i < 16; i++) do_write(16'h2000 + 16'(i), 0, 8'h77, "R2 dirty");
    reset_req = 1;
    @(negedge clk); reset_req = 0;
    repeat (400) @(negedge clk);
    chk(busy == 1, "R9 mid fill", busy, 1);
    reset_req = 1;
    @(negedge clk); reset_req = 0;
    model_fill();
    count_busy(1024, 900, "R9 restart fill length");
    sweep(0, "R9 after restart");
    report();
  end
endmodule